// File: doc/BRIEF.md
# NAND Flash Read-Only Device Model

This block is a synthesizable slave model of a small read-only NAND flash pair. It sits on a shared 8-bit bus with a command-latch strobe, an address-latch strobe, active-low read and write strobes and two active-low chip selects. Each chip select owns a separate storage bank and a separate decode state machine. Command bytes pick one of three read modes, and three address bytes build a linear byte pointer. Each read strobe then returns the next sequential byte.

Pages are 528 bytes long. The read command chooses a starting column offset of 0, 256 or 512. Of the two page address bytes, the first counts in blocks of 256 pages and the second counts in single pages. All pins are synchronized to the system clock before they are decoded. Storage depth is `PAGE_BYTES*PAGES`, and the pointer wraps modulo that depth so that a small array can stand in for a large part.

Top module: `nand_read_model`

## Requirements
- R1: After reset both devices are idle with pointer 0, `rdy` is 2'b00, `bus_oe` is 0 and `err` is 2'b00.
- R2: Command 0x00 selects read mode A, 0x01 selects mode B and 0x50 selects mode C. Each of these clears the address-byte count. Command 0xFF returns the device to idle.
- R3: The first address byte after a read command loads the pointer with the byte plus a column offset: 0 in mode A, 256 in mode B, 512 in mode C.
- R4: The second address byte adds byte*PAGE_BYTES*256 to the pointer and the third adds byte*PAGE_BYTES. Storage is indexed by pointer modulo PAGE_BYTES*PAGES.
- R5: Each falling read strobe puts the byte at the current pointer on `bus_out` and advances the pointer by one. With FILL_MODE=0 every byte is 0xFF. With FILL_MODE=1 the byte at index i of device d is (13*i + (i>>8) + 53*d) mod 256.
- R6: `ce0_n` low selects device 0 whatever `ce1_n` is. Otherwise `ce1_n` low selects device 1. With neither low, all bus activity is ignored.
- R7: While a device is selected and both strobes are high, its ready bit goes high (bit 0 for device 0, bit 1 for device 1) and the other bit stays low. Otherwise `rdy` is 0.
- R8: `bus_oe` rises after a selected falling read strobe and falls once both strobes are high with a device selected.
- R9: A byte is latched on the rising write strobe: as a command when `cle` is high (even if `ale` is also high), as an address when only `ale` is high, and not at all when neither is high.
- R10: An address byte in idle, a fourth address byte, or an unknown command sets that device's sticky `err` bit. Mode and pointer are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_in | input | 8 | Bus byte driven by the host |
| bus_out | output | 8 | Read byte driven toward the host |
| bus_oe | output | 1 | High while the model drives the bus |
| cle | input | 1 | Command-latch strobe |
| ale | input | 1 | Address-latch strobe |
| re_n | input | 1 | Active-low read strobe |
| we_n | input | 1 | Active-low write strobe |
| ce0_n | input | 1 | Active-low select of device 0 |
| ce1_n | input | 1 | Active-low select of device 1 |
| rdy | output | 2 | Per-device ready lines |
| err | output | 2 | Per-device sticky protocol error |

## Verification
The bench sweeps every read mode, both page bytes, two block values and several columns on both devices, and predicts every byte from the fill formula. A design that swapped the column offsets or the address weights returns wrong bytes at once. A pointer that starts at 1055 must wrap to index 0; a model without the modulo reads past its storage. Both selects low must reach device 0 only, and a write with neither latch strobe, or with no device selected, must leave `err` clear. Error cases must leave the pointer alone; a design that advanced the address count on a rejected byte would return a different next byte.

// File: rtl/nrm_pkg.sv
package nrm_pkg;

   typedef enum logic [1:0] {
      M_IDLE = 2'd0,
      M_RDA  = 2'd1,
      M_RDB  = 2'd2,
      M_RDC  = 2'd3
   } rmode_t;

   localparam logic [7:0] OP_RESET = 8'hFF;
   localparam logic [7:0] OP_RDA   = 8'h00;
   localparam logic [7:0] OP_RDB   = 8'h01;
   localparam logic [7:0] OP_RDC   = 8'h50;

   // Power-up content of a storage cell
   function automatic logic [7:0] fill_byte(int unsigned idx, int unsigned dev,
                                            int unsigned mode);
      int unsigned v;
      if (mode == 0) return 8'hFF;
      v = idx * 13 + (idx >> 8) + dev * 53;
      return v[7:0];
   endfunction

endpackage

// File: rtl/nrm_sync.sv
module nrm_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("nrm_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/nrm_bank.sv
module nrm_bank
   import nrm_pkg::*;
#(
   parameter int DEPTH     = 1056,
   parameter int DEV_ID    = 0,
   parameter int FILL_MODE = 0,
   parameter int AW        = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("nrm_bank: DEPTH too small");
   end

   logic [7:0] cells [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++)
            cells[i] <= fill_byte(i, DEV_ID, FILL_MODE);
      end
   end

   assign rdata = cells[raddr];

endmodule

// File: rtl/nrm_dev.sv
module nrm_dev
   import nrm_pkg::*;
#(
   parameter int PAGE_BYTES = 528,
   parameter int PAGES      = 2,
   parameter int PTR_W      = 32,
   parameter int DEV_ID     = 0,
   parameter int FILL_MODE  = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_evt,
   input  logic       addr_evt,
   input  logic       rd_evt,
   input  logic [7:0] bus_byte,
   output logic [7:0] rd_byte,
   output logic       err
);

   localparam int                DEPTH     = PAGE_BYTES * PAGES;
   localparam int                AW        = $clog2(DEPTH);
   localparam logic [PTR_W-1:0]  STRIDE_LO = PTR_W'(PAGE_BYTES);
   localparam logic [PTR_W-1:0]  STRIDE_HI = PTR_W'(PAGE_BYTES * 256);
   localparam logic [PTR_W-1:0]  DEPTH_W   = PTR_W'(DEPTH);

   logic [PTR_W-1:0] raw_ptr;
   logic [PTR_W-1:0] col_base;
   logic [AW-1:0]    idx;
   logic [7:0]       bank_byte;
   logic [1:0]       acnt;
   rmode_t           mode;
   logic             known_op;
   logic             addr_bad;

   assign idx      = AW'(raw_ptr % DEPTH_W);
   assign known_op = (bus_byte == OP_RESET) || (bus_byte == OP_RDA) ||
                     (bus_byte == OP_RDB)   || (bus_byte == OP_RDC);
   assign addr_bad = (mode == M_IDLE) || (acnt == 2'd3);

   always_comb begin
      case (mode)
         M_RDB:   col_base = PTR_W'(256);
         M_RDC:   col_base = PTR_W'(512);
         default: col_base = '0;
      endcase
   end

   nrm_bank #(
      .DEPTH     (DEPTH),
      .DEV_ID    (DEV_ID),
      .FILL_MODE (FILL_MODE),
      .AW        (AW)
   ) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .raddr (idx),
      .rdata (bank_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode    <= M_IDLE;
         acnt    <= 2'd0;
         raw_ptr <= '0;
         rd_byte <= 8'h00;
         err     <= 1'b0;
      end else if (cmd_evt) begin
         case (bus_byte)
            OP_RESET: begin mode <= M_IDLE; acnt <= 2'd0; end
            OP_RDA:   begin mode <= M_RDA;  acnt <= 2'd0; end
            OP_RDB:   begin mode <= M_RDB;  acnt <= 2'd0; end
            OP_RDC:   begin mode <= M_RDC;  acnt <= 2'd0; end
            default:  err <= 1'b1;
         endcase
      end else if (addr_evt) begin
         if (addr_bad) begin
            err <= 1'b1;
         end else begin
            case (acnt)
               2'd0:    raw_ptr <= PTR_W'(bus_byte) + col_base;
               2'd1:    raw_ptr <= raw_ptr + PTR_W'(bus_byte) * STRIDE_HI;
               default: raw_ptr <= raw_ptr + PTR_W'(bus_byte) * STRIDE_LO;
            endcase
            acnt <= acnt + 2'd1;
         end
      end else if (rd_evt) begin
         rd_byte <= bank_byte;
         raw_ptr <= raw_ptr + PTR_W'(1);
      end
   end

   // R5: a read moves the pointer by exactly one
   p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_evt && !cmd_evt && !addr_evt) |=> raw_ptr == $past(raw_ptr) + PTR_W'(1));

   // R2: a read command leaves a non-idle mode and a cleared count
   p_cmd_clears_cnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_evt && known_op && bus_byte != OP_RESET) |=> (acnt == 2'd0 && mode != M_IDLE));

   // R10: error bit is sticky until reset
   p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   // R10: an unknown command changes neither mode nor pointer
   p_bad_cmd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_evt && !known_op) |=> ($stable(mode) && $stable(raw_ptr)));

endmodule

// File: rtl/nand_read_model.sv
module nand_read_model
   import nrm_pkg::*;
#(
   parameter int PAGE_BYTES  = 528,
   parameter int PAGES       = 2,
   parameter int SYNC_STAGES = 2,
   parameter int PTR_W       = 32,
   parameter int FILL_MODE   = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] bus_in,
   output logic [7:0] bus_out,
   output logic       bus_oe,
   input  logic       cle,
   input  logic       ale,
   input  logic       re_n,
   input  logic       we_n,
   input  logic       ce0_n,
   input  logic       ce1_n,
   output logic [1:0] rdy,
   output logic [1:0] err
);

   localparam int             NDEV     = 2;
   localparam int             BW       = 14;
   localparam logic [BW-1:0]  PIN_IDLE = {4'hF, 2'b00, 8'h00};

   if (PAGES < 1 || PAGE_BYTES < 513) begin : g_bad_geom
      $error("nand_read_model: geometry must hold the 512 column offset");
   end
   if (PTR_W < 24) begin : g_bad_ptr
      $error("nand_read_model: PTR_W must be at least 24");
   end
   if (FILL_MODE != 0 && FILL_MODE != 1) begin : g_bad_fill
      $error("nand_read_model: FILL_MODE must be 0 or 1");
   end

   // ---------------- pin synchronization and edge detection
   logic [BW-1:0] pins_raw, s_pins, p_pins;

   assign pins_raw = {ce1_n, ce0_n, re_n, we_n, ale, cle, bus_in};

   nrm_sync #(
      .W       (BW),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PIN_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pins_raw),
      .q     (s_pins)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) p_pins <= PIN_IDLE;
      else        p_pins <= s_pins;
   end

   logic [7:0] p_data;
   logic       p_cle, p_ale, p_we_n, p_re_n, p_ce0_n, p_ce1_n;
   logic       s_we_n, s_re_n, s_ce0_n, s_ce1_n;

   assign p_data  = p_pins[7:0];
   assign p_cle   = p_pins[8];
   assign p_ale   = p_pins[9];
   assign p_we_n  = p_pins[10];
   assign p_re_n  = p_pins[11];
   assign p_ce0_n = p_pins[12];
   assign p_ce1_n = p_pins[13];
   assign s_we_n  = s_pins[10];
   assign s_re_n  = s_pins[11];
   assign s_ce0_n = s_pins[12];
   assign s_ce1_n = s_pins[13];

   // device 0 wins when both selects are low
   logic s_sel_any, s_sel_dev, p_sel_any, p_sel_dev;
   assign s_sel_any = !(s_ce0_n && s_ce1_n);
   assign s_sel_dev = s_ce0_n;
   assign p_sel_any = !(p_ce0_n && p_ce1_n);
   assign p_sel_dev = p_ce0_n;

   logic we_rise, cmd_hit, addr_hit, re_fall, bus_quiet;
   assign we_rise   = s_we_n && !p_we_n && p_sel_any;
   assign cmd_hit   = we_rise && p_cle;
   assign addr_hit  = we_rise && !p_cle && p_ale;
   assign re_fall   = !s_re_n && p_re_n && s_sel_any;
   assign bus_quiet = s_sel_any && s_re_n && s_we_n;

   // ---------------- per-device decode
   logic [7:0] dev_byte [NDEV];

   for (genvar g = 0; g < NDEV; g++) begin : g_dev
      logic hit_me_w, hit_me_r;
      assign hit_me_w = (p_sel_dev == 1'(g));
      assign hit_me_r = (s_sel_dev == 1'(g));

      nrm_dev #(
         .PAGE_BYTES (PAGE_BYTES),
         .PAGES      (PAGES),
         .PTR_W      (PTR_W),
         .DEV_ID     (g),
         .FILL_MODE  (FILL_MODE)
      ) u_dev (
         .clk      (clk),
         .rst_n    (rst_n),
         .cmd_evt  (cmd_hit && hit_me_w),
         .addr_evt (addr_hit && hit_me_w),
         .rd_evt   (re_fall && hit_me_r),
         .bus_byte (p_data),
         .rd_byte  (dev_byte[g]),
         .err      (err[g])
      );
   end

   // ---------------- bus direction, data return, ready
   logic rd_src;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_src <= 1'b0;
         bus_oe <= 1'b0;
         rdy    <= 2'b00;
      end else begin
         if (re_fall) begin
            rd_src <= s_sel_dev;
            bus_oe <= 1'b1;
         end else if (bus_quiet) begin
            bus_oe <= 1'b0;
         end
         rdy <= bus_quiet ? (2'b01 << s_sel_dev) : 2'b00;
      end
   end

   assign bus_out = dev_byte[rd_src];

   // R7: at most one ready line
   p_rdy_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rdy));

   // R7, R8: a ready device never drives the bus
   p_rdy_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|rdy) |-> !bus_oe);

   // R8: the bus turns around only after a read strobe
   p_oe_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_oe) |-> $past(!s_re_n));

endmodule

// File: tb/nand_read_model_tb.sv
module nand_read_model_tb_top;

   localparam int PB    = 528;
   localparam int PG    = 2;
   localparam int DEPTH = PB * PG;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] bus_in;
   logic       cle, ale, re_n, we_n, ce0_n, ce1_n;
   logic [7:0] bus_out, bus_out_ff;
   logic       bus_oe, bus_oe_ff;
   logic [1:0] rdy, err, rdy_ff, err_ff;

   always #10 clk = ~clk;

   nand_read_model #(.PAGE_BYTES(PB), .PAGES(PG), .FILL_MODE(1)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
      .cle(cle), .ale(ale), .re_n(re_n), .we_n(we_n), .ce0_n(ce0_n), .ce1_n(ce1_n),
      .rdy(rdy), .err(err));

   nand_read_model #(.PAGE_BYTES(PB), .PAGES(PG), .FILL_MODE(0)) dut_ff_i (
      .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .bus_out(bus_out_ff), .bus_oe(bus_oe_ff),
      .cle(cle), .ale(ale), .re_n(re_n), .we_n(we_n), .ce0_n(ce0_n), .ce1_n(ce1_n),
      .rdy(rdy_ff), .err(err_ff));

   int n_cmp = 0;
   int n_bad = 0;
   int exp_ptr [2];
   bit done = 0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wt(int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [7:0] expb(int d, int p);
      int i;
      i = p % DEPTH;
      return 8'((i * 13 + (i >> 8) + d * 53) & 255);
   endfunction

   // 0: device 0, 1: device 1, 2: both selects low, 3: none
   task automatic sel(int d);
      ce0_n = !(d == 0 || d == 2);
      ce1_n = !(d == 1 || d == 2);
   endtask

   task automatic wr(int d, bit is_cmd, bit is_addr, logic [7:0] b);
      sel(d); cle = is_cmd; ale = is_addr; bus_in = b;
      wt(2); we_n = 0; wt(6); we_n = 1; wt(6);
      cle = 0; ale = 0; sel(3); wt(3);
   endtask

   task automatic set_ptr(int d, int m, int col, int a1, int a2);
      logic [7:0] op;
      int dd;
      dd = (d == 1) ? 1 : 0;
      op = (m == 0) ? 8'h00 : (m == 1) ? 8'h01 : 8'h50;
      wr(d, 1, 0, op);
      wr(d, 0, 1, 8'(col));
      wr(d, 0, 1, 8'(a1));
      wr(d, 0, 1, 8'(a2));
      exp_ptr[dd] = col + m * 256 + a1 * PB * 256 + a2 * PB;
   endtask

   task automatic rd(int d, string tag);
      int dd;
      dd = (d == 1) ? 1 : 0;
      sel(d); wt(2); re_n = 0; wt(6);
      if (d < 3) begin
         chk({"R8 oe during read ", tag}, bus_oe, 1);
         chk({"R5 data ", tag}, bus_out, expb(dd, exp_ptr[dd]));
         chk({"R5 blank fill ", tag}, bus_out_ff, 8'hFF);
         exp_ptr[dd]++;
      end else begin
         chk({"R6 unselected read ", tag}, bus_oe, 0);
      end
      re_n = 1; wt(6);
      chk({"R7 ready ", tag}, rdy, (d < 3) ? (dd == 0 ? 2'b01 : 2'b10) : 2'b00);
      chk({"R8 oe released ", tag}, bus_oe, 0);
      sel(3); wt(3);
   endtask

   task automatic do_reset();
      rst_n = 0; wt(4); rst_n = 1; wt(3);
      exp_ptr[0] = 0; exp_ptr[1] = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int cols [4] = '{0, 5, 200, 255};
      bus_in = 0; cle = 0; ale = 0; re_n = 1; we_n = 1; ce0_n = 1; ce1_n = 1;
      rst_n = 0;
      wt(5);
      // R1: reset state
      chk("R1 rdy after reset", rdy, 2'b00);
      chk("R1 oe after reset", bus_oe, 0);
      chk("R1 err after reset", err, 2'b00);
      rst_n = 1; wt(3);
      exp_ptr[0] = 0; exp_ptr[1] = 0;
      chk("R1 rdy idle unselected", rdy, 2'b00);

      // R2 R3 R4 R5: sweep modes, block byte, page byte and column
      for (int d = 0; d < 2; d++)
         for (int m = 0; m < 3; m++)
            for (int a1 = 0; a1 < 2; a1++)
               for (int a2 = 0; a2 < PG; a2++)
                  for (int c = 0; c < 4; c++) begin
                     set_ptr(d, m, cols[c], a1, a2);
                     rd(d, "R3 sweep");
                     rd(d, "R4 sweep");
                  end
      chk("R10 no error after legal traffic", err, 2'b00);

      // R10: address while idle on device 1
      do_reset();
      wr(1, 1, 0, 8'hFF);
      wr(1, 0, 1, 8'h12);
      chk("R10 idle address err", err, 2'b10);
      rd(1, "R10 pointer untouched by idle address");

      // R4: wrap at end of storage, then R10: fourth address byte
      do_reset();
      set_ptr(0, 2, 15, 0, 1);
      chk("R4 pointer at last cell", exp_ptr[0], DEPTH - 1);
      rd(0, "R4 last cell");
      rd(0, "R4 wrapped to zero");
      chk("R10 err clear before fourth byte", err, 2'b00);
      wr(0, 0, 1, 8'h77);
      chk("R10 fourth address err", err, 2'b01);
      rd(0, "R10 pointer kept after fourth byte");

      // R10: unknown command keeps mode and pointer
      do_reset();
      set_ptr(0, 0, 3, 0, 0);
      wr(0, 1, 0, 8'h30);
      chk("R10 unknown command err", err, 2'b01);
      rd(0, "R10 pointer kept after unknown command");
      wr(0, 0, 1, 8'h09);
      chk("R10 err stays set", err, 2'b01);

      // R6: both selects low reach device 0 only; no select is ignored
      do_reset();
      set_ptr(2, 1, 7, 0, 1);
      rd(2, "R6 both selects low");
      rd(3, "R6 no select");
      rd(0, "R6 pointer kept after unselected read");
      wr(3, 0, 1, 8'h44);
      chk("R6 unselected address ignored", err, 2'b00);
      rd(1, "R6 device 1 untouched");

      // R9: cle wins over ale; write with neither is ignored
      do_reset();
      wr(0, 1, 1, 8'h01);
      wr(0, 0, 1, 8'h02);
      wr(0, 0, 1, 8'h00);
      wr(0, 0, 1, 8'h00);
      exp_ptr[0] = 256 + 2;
      chk("R9 cle over ale no err", err, 2'b00);
      rd(0, "R9 cle over ale mode B");
      wr(0, 0, 0, 8'h50);
      chk("R9 plain write ignored", err, 2'b00);
      rd(0, "R9 pointer after plain write");

      // R2: reset command then read command restarts address count
      wr(0, 1, 0, 8'hFF);
      wr(0, 1, 0, 8'h50);
      wr(0, 0, 1, 8'h01);
      exp_ptr[0] = 513;
      chk("R2 reset then mode C no err", err, 2'b00);
      rd(0, "R2 mode C after reset command");

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule